// File: doc/BRIEF.md
# Speech Chip Command Sequencer

This block sits between a host and a speech synthesis chip. The chip is driven by a two-bit command code and one command strobe. The host makes three kinds of request: initialise the chip, speak the utterance stored at a 16-bit address, or poll whether speech has finished. The sequencer turns each request into the strobe, code and byte-load pulse pattern that the chip needs, and it makes every pulse at least 6.25 µs wide. One shared cycle counter, sized from the system clock frequency, times all phases.

A speak request first presents the low address byte with its own active-low load strobe. The high byte follows with a second load strobe. A single talk command then starts the utterance. A poll runs the three-toggle status handshake. It samples the chip's status line while the line is enabled, reports whether speech is still running, and gives a one-cycle completion pulse that can serve as an interrupt. A speak request made while an utterance is still tracked is held. The sequencer then polls the chip by itself until speech ends, and only after that issues the held request.

Top module: `vox_cmd_seq`

## Requirements
- R1: After reset, cmd_stb is low, load_lo_n and load_hi_n are high, cmd_code is 2'b00, ready is high, and speaking and done_pulse are low.
- R2: An init request drives code 2'b11 (bit 1 = first control line, bit 0 = second) for three cmd_stb rising edges, then code 2'b00 for three rising edges. It also clears speaking and any tracked utterance, so a later poll gives no done_pulse.
- R3: Each cmd_stb high phase, each low phase and each load strobe low phase lasts exactly HOLD cycles, where HOLD = ceil(PULSE_NS × CLK_HZ / 1e9) (4 at 640 kHz). cmd_code does not change in a cycle where cmd_stb is high, and it is set up at least HOLD cycles before the first rise.
- R4: A speak request drives the low address byte on data_out with load_lo_n low, then the high byte with load_hi_n low. The two load strobes are never low together, and data_out is stable while either is low.
- R5: After both loads, exactly one cmd_stb rise with code 2'b01 follows. speaking is then high and an utterance is tracked.
- R6: A poll request gives three cmd_stb rises with code 2'b00. stat_in is sampled in the last cycle of the low phase after the second rise, and speaking becomes the inverse of that sample.
- R7: done_pulse is high for exactly one cycle when a poll samples stat_in high while an utterance is tracked. It is never high otherwise.
- R8: A speak request made while an utterance is tracked makes no load pulse until a self-issued poll samples stat_in high. ready stays low in the meantime, and the held address is then loaded and spoken.
- R9: The code 2'b10 never appears on cmd_code.
- R10: A request made while ready is low is dropped. When requests arrive together, init wins over speak, and speak wins over poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | Request chip initialisation (one cycle) |
| speak_req | input | 1 | Request an utterance at speak_addr (one cycle) |
| poll_req | input | 1 | Request a status poll (one cycle) |
| speak_addr | input | 16 | Start address of the utterance |
| ready | output | 1 | Sequencer idle and accepting a request |
| speaking | output | 1 | Last known talk state of the chip |
| done_pulse | output | 1 | One-cycle pulse when speech is seen to end |
| cmd_code | output | 2 | Command code to the chip (bit 1 first line, bit 0 second line) |
| cmd_stb | output | 1 | Command strobe to the chip |
| data_out | output | 8 | Address byte bus to the address counter |
| load_lo_n | output | 1 | Low-byte load strobe, active low |
| load_hi_n | output | 1 | High-byte load strobe, active low |
| stat_in | input | 1 | Chip status line, high when status is enabled and speech has ended |

## Verification
A wrong phase or toggle count shows at the chip pins within one strobe period. It appears as an extra or missing cmd_stb rise, or as a rise under the wrong code, and a scoreboard of expected strobe and load events catches it at that rise. A corrupted utterance flag or held-request flag shows only at the next poll: as a missing or extra done_pulse, as speaking with the wrong value, or as load strobes that appear while the modelled chip is still talking. A phase timer that is off by a cycle shows on the first strobe, because its width is measured against HOLD.

// File: rtl/vox_seq_pkg.sv
package vox_seq_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned TOG_W  = 4;

    // Command codes: bit 1 = first control line, bit 0 = second control line
    localparam logic [1:0] CODE_TEST  = 2'b00;
    localparam logic [1:0] CODE_TALK  = 2'b01;
    localparam logic [1:0] CODE_RESET = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STB_HI,
        ST_STB_LO,
        ST_LD_LO,
        ST_GAP_LO,
        ST_LD_HI,
        ST_GAP_HI
    } phase_e;

    typedef enum logic [1:0] {
        JOB_RST,
        JOB_TST,
        JOB_TALK,
        JOB_POLL
    } job_e;

    typedef struct packed {
        phase_e            st;
        job_e              job;
        logic [TOG_W-1:0]  tog;
        logic [1:0]        code;
        logic              stb;
        logic              ld_lo_n;
        logic              ld_hi_n;
        logic [BYTE_W-1:0] data;
        logic              utt;
        logic              spk;
        logic              done;
        logic              pend;
    } seq_t;

    // Cycles needed to cover a pulse of ns nanoseconds at hz, rounded up
    function automatic int unsigned hold_cycles(input longint unsigned hz,
                                                input longint unsigned ns);
        longint unsigned c;
        c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) begin
            c = 1;
        end
        return 32'(c);
    endfunction

endpackage

// File: rtl/vox_phase_timer.sv
module vox_phase_timer #(
    parameter int unsigned HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned CW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart || (cnt_q == LAST)) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = !restart && (cnt_q == LAST);

endmodule

// File: rtl/vox_addr_hold.sv
module vox_addr_hold
    import vox_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic [2*BYTE_W-1:0] addr_in,
    output logic [BYTE_W-1:0]   lo_byte,
    output logic [BYTE_W-1:0]   hi_byte
);
    logic [2*BYTE_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = capture ? addr_in : addr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign lo_byte = addr_q[BYTE_W-1:0];
    assign hi_byte = addr_q[2*BYTE_W-1:BYTE_W];

endmodule

// File: rtl/vox_cmd_seq.sv
module vox_cmd_seq
    import vox_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 640_000,
    parameter int unsigned PULSE_NS    = 6250,
    parameter int unsigned RST_TOGGLES = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_req,
    input  logic                speak_req,
    input  logic                poll_req,
    input  logic [2*BYTE_W-1:0] speak_addr,
    output logic                ready,
    output logic                speaking,
    output logic                done_pulse,
    output logic [1:0]          cmd_code,
    output logic                cmd_stb,
    output logic [BYTE_W-1:0]   data_out,
    output logic                load_lo_n,
    output logic                load_hi_n,
    input  logic                stat_in
);
    localparam int unsigned HOLD = hold_cycles(64'(CLK_HZ), 64'(PULSE_NS));
    localparam logic [TOG_W-1:0] RST_LAST   = TOG_W'(RST_TOGGLES - 1);
    localparam logic [TOG_W-1:0] HS_LAST    = TOG_W'(2);
    localparam logic [TOG_W-1:0] HS_SAMPLE  = TOG_W'(1);

    seq_t seq_d, seq_q;
    logic tick;
    logic cap_en;
    logic [TOG_W-1:0] last_tog;
    logic [BYTE_W-1:0] lat_lo, lat_hi;

    vox_phase_timer #(.HOLD(HOLD)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (seq_q.st == ST_IDLE),
        .tick    (tick)
    );

    vox_addr_hold u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_en),
        .addr_in (speak_addr),
        .lo_byte (lat_lo),
        .hi_byte (lat_hi)
    );

    function automatic seq_t begin_cmd(input seq_t s, input job_e j, input logic [1:0] c);
        seq_t r;
        r      = s;
        r.st   = ST_SETUP;
        r.job  = j;
        r.code = c;
        r.tog  = '0;
        r.stb  = 1'b0;
        return r;
    endfunction

    always_comb begin
        case (seq_q.job)
            JOB_RST:  last_tog = RST_LAST;
            JOB_TALK: last_tog = '0;
            default:  last_tog = HS_LAST;
        endcase
    end

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        cap_en     = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (init_req) begin
                    seq_d      = begin_cmd(seq_q, JOB_RST, CODE_RESET);
                    seq_d.utt  = 1'b0;
                    seq_d.spk  = 1'b0;
                    seq_d.pend = 1'b0;
                end else if (speak_req) begin
                    cap_en = 1'b1;
                    if (seq_q.utt) begin
                        seq_d      = begin_cmd(seq_q, JOB_POLL, CODE_TEST);
                        seq_d.pend = 1'b1;
                    end else begin
                        seq_d.st      = ST_LD_LO;
                        seq_d.data    = speak_addr[BYTE_W-1:0];
                        seq_d.ld_lo_n = 1'b0;
                    end
                end else if (poll_req) begin
                    seq_d = begin_cmd(seq_q, JOB_POLL, CODE_TEST);
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    seq_d.st  = ST_STB_HI;
                    seq_d.stb = 1'b1;
                end
            end
            ST_STB_HI: begin
                if (tick) begin
                    seq_d.st  = ST_STB_LO;
                    seq_d.stb = 1'b0;
                end
            end
            ST_STB_LO: begin
                if (tick) begin
                    if ((seq_q.job == JOB_POLL) && (seq_q.tog == HS_SAMPLE)) begin
                        seq_d.spk = !stat_in;
                        if (stat_in) begin
                            seq_d.utt  = 1'b0;
                            seq_d.done = seq_q.utt;
                        end
                    end
                    if (seq_q.tog == last_tog) begin
                        case (seq_q.job)
                            JOB_RST: begin
                                seq_d = begin_cmd(seq_d, JOB_TST, CODE_TEST);
                            end
                            JOB_TST: begin
                                seq_d.st = ST_IDLE;
                            end
                            JOB_TALK: begin
                                seq_d.st  = ST_IDLE;
                                seq_d.utt = 1'b1;
                                seq_d.spk = 1'b1;
                            end
                            default: begin
                                if (!seq_q.pend) begin
                                    seq_d.st = ST_IDLE;
                                end else if (seq_q.utt) begin
                                    seq_d = begin_cmd(seq_d, JOB_POLL, CODE_TEST);
                                end else begin
                                    seq_d.pend    = 1'b0;
                                    seq_d.st      = ST_LD_LO;
                                    seq_d.data    = lat_lo;
                                    seq_d.ld_lo_n = 1'b0;
                                end
                            end
                        endcase
                    end else begin
                        seq_d.tog = seq_q.tog + 1'b1;
                        seq_d.st  = ST_STB_HI;
                        seq_d.stb = 1'b1;
                    end
                end
            end
            ST_LD_LO: begin
                if (tick) begin
                    seq_d.st      = ST_GAP_LO;
                    seq_d.ld_lo_n = 1'b1;
                end
            end
            ST_GAP_LO: begin
                if (tick) begin
                    seq_d.st      = ST_LD_HI;
                    seq_d.data    = lat_hi;
                    seq_d.ld_hi_n = 1'b0;
                end
            end
            ST_LD_HI: begin
                if (tick) begin
                    seq_d.st      = ST_GAP_HI;
                    seq_d.ld_hi_n = 1'b1;
                end
            end
            ST_GAP_HI: begin
                if (tick) begin
                    seq_d = begin_cmd(seq_q, JOB_TALK, CODE_TALK);
                end
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st      <= ST_IDLE;
            seq_q.job     <= JOB_RST;
            seq_q.tog     <= '0;
            seq_q.code    <= CODE_TEST;
            seq_q.stb     <= 1'b0;
            seq_q.ld_lo_n <= 1'b1;
            seq_q.ld_hi_n <= 1'b1;
            seq_q.data    <= '0;
            seq_q.utt     <= 1'b0;
            seq_q.spk     <= 1'b0;
            seq_q.done    <= 1'b0;
            seq_q.pend    <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready      = (seq_q.st == ST_IDLE);
    assign speaking   = seq_q.spk;
    assign done_pulse = seq_q.done;
    assign cmd_code   = seq_q.code;
    assign cmd_stb    = seq_q.stb;
    assign data_out   = seq_q.data;
    assign load_lo_n  = seq_q.ld_lo_n;
    assign load_hi_n  = seq_q.ld_hi_n;

endmodule

// File: rtl/vox_cmd_seq_chk.sv
module vox_cmd_seq_chk #(
    parameter int unsigned HOLD = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cmd_code,
    input logic       cmd_stb,
    input logic       load_lo_n,
    input logic       load_hi_n,
    input logic [7:0] data_out,
    input logic       done_pulse
);
    logic [15:0] hi_cnt, lo_cnt;
    logic        lo_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt  <= '0;
            lo_cnt  <= '0;
            lo_seen <= 1'b0;
        end else begin
            hi_cnt <= cmd_stb ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1) : 16'd0;
            lo_cnt <= !load_lo_n ? ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 16'd1) : 16'd0;
            if (!load_lo_n) begin
                lo_seen <= 1'b1;
            end else if (!load_hi_n) begin
                lo_seen <= 1'b0;
            end
        end
    end

    // R9
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_code != 2'b10);

    // R3
    stb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_stb) |-> (hi_cnt == 16'(HOLD)));

    // R3
    ld_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_lo_n) |-> (lo_cnt == 16'(HOLD)));

    // R3
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> $stable(cmd_code));

    // R4
    ld_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!load_lo_n && !load_hi_n));

    // R4
    ld_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_hi_n) |-> lo_seen);

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!load_lo_n && $past(!load_lo_n)) || (!load_hi_n && $past(!load_hi_n))) |-> $stable(data_out));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

endmodule

bind vox_cmd_seq vox_cmd_seq_chk #(.HOLD(HOLD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_code   (cmd_code),
    .cmd_stb    (cmd_stb),
    .load_lo_n  (load_lo_n),
    .load_hi_n  (load_hi_n),
    .data_out   (data_out),
    .done_pulse (done_pulse)
);

// File: tb/sim_vox_cmd_seq.sv
module sim_vox_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD_EXP   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_req = 1'b0, speak_req = 1'b0, poll_req = 1'b0;
    logic [15:0] speak_addr = '0;
    logic        ready, speaking, done_pulse, cmd_stb, load_lo_n, load_hi_n, stat_in;
    logic [1:0]  cmd_code;
    logic [7:0]  data_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    vox_cmd_seq #(.CLK_HZ(640_000), .PULSE_NS(6250), .RST_TOGGLES(3)) u0 (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .speak_req(speak_req),
        .poll_req(poll_req), .speak_addr(speak_addr), .ready(ready),
        .speaking(speaking), .done_pulse(done_pulse), .cmd_code(cmd_code),
        .cmd_stb(cmd_stb), .data_out(data_out), .load_lo_n(load_lo_n),
        .load_hi_n(load_hi_n), .stat_in(stat_in)
    );

    // Chip model
    int   talk_gen = 0, end_gen = 0, rst_gen = 0, hs = 0;
    logic st_en = 1'b0;
    logic chip_talking;
    always @(posedge cmd_stb) begin
        if (cmd_code == 2'b11) begin
            hs = 0; st_en = 1'b0; rst_gen = talk_gen;
        end else if (cmd_code == 2'b01) begin
            talk_gen = talk_gen + 1;
        end else if (cmd_code == 2'b00) begin
            if (hs == 0) hs = 1;
            else if (hs == 1) begin hs = 2; st_en = 1'b1; end
            else begin hs = 0; st_en = 1'b0; end
        end
    end
    assign chip_talking = (talk_gen != end_gen) && (talk_gen != rst_gen);
    assign stat_in = st_en & ~chip_talking;

    // Scoreboard
    int n_chk = 0, n_err = 0;
    logic [15:0] exp_q[$];
    string       req_q[$];
    bit          skip_polls = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_ev(input string r, input logic [15:0] e);
        exp_q.push_back(e);
        req_q.push_back(r);
    endtask

    task automatic expect_rises(input string r, input logic [1:0] c, input int n);
        for (int k = 0; k < n; k++) expect_ev(r, {8'h01, 6'h00, c});
    endtask

    task automatic expect_speak(input logic [15:0] a);
        expect_ev("R4", {8'h02, a[7:0]});
        expect_ev("R4", {8'h03, a[15:8]});
        expect_ev("R5", {8'h01, 8'h01});
    endtask

    task automatic got(input logic [15:0] ev);
        if (exp_q.size() == 0) begin
            chk(1'b0, "R10", int'(ev), 0);
        end else begin
            logic [15:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            chk(ev == e, r, int'(ev), int'(e));
        end
    endtask

    // Monitor
    logic stb_p = 1'b0, lo_p = 1'b1, hi_p = 1'b1;
    int   hi_w = 0, lo_w = 0, lh_w = 0, done_run = 0, done_cnt = 0, ld_cnt = 0, bad_code = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_code == 2'b10) bad_code++;
            if (cmd_stb) hi_w++;
            if (cmd_stb && !stb_p && !(skip_polls && cmd_code == 2'b00))
                got({8'h01, 6'h00, cmd_code});
            if (!cmd_stb && stb_p) begin
                chk(hi_w == HOLD_EXP, "R3", hi_w, HOLD_EXP);
                hi_w = 0;
            end
            if (!load_lo_n) lo_w++;
            if (!load_hi_n) lh_w++;
            if (!load_lo_n && lo_p) begin
                got({8'h02, data_out});
                ld_cnt++;
                if (chip_talking) chk(1'b0, "R8", 1, 0);
            end
            if (!load_hi_n && hi_p) got({8'h03, data_out});
            if (!load_lo_n && !load_hi_n) chk(1'b0, "R4", 0, 1);
            if (load_lo_n && !lo_p) begin
                chk(lo_w == HOLD_EXP, "R3", lo_w, HOLD_EXP);
                lo_w = 0;
            end
            if (load_hi_n && !hi_p) begin
                chk(lh_w == HOLD_EXP, "R3", lh_w, HOLD_EXP);
                lh_w = 0;
            end
            if (done_pulse) begin done_cnt++; done_run++; end
            else done_run = 0;
            if (done_run > 1) chk(1'b0, "R7", done_run, 1);
        end
        stb_p = cmd_stb; lo_p = load_lo_n; hi_p = load_hi_n;
    end

    // Driver
    task automatic fire(input bit i, input bit s, input bit p, input logic [15:0] a);
        @(negedge clk);
        init_req = i; speak_req = s; poll_req = p; speak_addr = a;
        @(negedge clk);
        init_req = 1'b0; speak_req = 1'b0; poll_req = 1'b0;
    endtask

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    task automatic do_init(input string r);
        expect_rises(r, 2'b11, 3);
        expect_rises(r, 2'b00, 3);
        fire(1'b1, 1'b0, 1'b0, 16'h0);
        wait_ready();
        chk(exp_q.size() == 0, r, exp_q.size(), 0);
    endtask

    task automatic do_poll(input string r);
        expect_rises(r, 2'b00, 3);
        fire(1'b0, 1'b0, 1'b1, 16'h0);
        wait_ready();
        chk(exp_q.size() == 0, r, exp_q.size(), 0);
    endtask

    initial begin
        int d0;
        int l0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd_stb == 1'b0, "R1", cmd_stb, 0);
        chk(load_lo_n && load_hi_n, "R1", {load_lo_n, load_hi_n}, 3);
        chk(cmd_code == 2'b00, "R1", cmd_code, 0);
        chk(ready == 1'b1, "R1", ready, 1);
        chk(!speaking && !done_pulse, "R1", {speaking, done_pulse}, 0);

        // R2 power-up sequence
        do_init("R2");

        // R4 R5 first utterance
        expect_speak(16'h12A5);
        fire(1'b0, 1'b1, 1'b0, 16'h12A5);
        wait_ready();
        chk(exp_q.size() == 0, "R4", exp_q.size(), 0);
        chk(speaking == 1'b1, "R5", speaking, 1);

        // R6 poll while talking
        d0 = done_cnt;
        do_poll("R6");
        chk(speaking == 1'b1, "R6", speaking, 1);
        chk(done_cnt == d0, "R7", done_cnt, d0);

        // R10 speak during busy poll is dropped
        expect_rises("R10", 2'b00, 3);
        fire(1'b0, 1'b0, 1'b1, 16'h0);
        fire(1'b0, 1'b1, 1'b0, 16'h7777);
        wait_ready();
        chk(exp_q.size() == 0, "R10", exp_q.size(), 0);
        chk(speaking == 1'b1, "R10", speaking, 1);

        // R6 R7 end of phrase seen by poll
        end_gen = talk_gen;
        d0 = done_cnt;
        do_poll("R6");
        chk(speaking == 1'b0, "R6", speaking, 0);
        chk(done_cnt == d0 + 1, "R7", done_cnt, d0 + 1);

        // R7 repeat poll: no second pulse
        d0 = done_cnt;
        do_poll("R7");
        chk(done_cnt == d0, "R7", done_cnt, d0);

        // R4 second address pattern
        expect_speak(16'h00FF);
        fire(1'b0, 1'b1, 1'b0, 16'h00FF);
        wait_ready();
        chk(exp_q.size() == 0, "R4", exp_q.size(), 0);

        // R8 hold-off of a speak while talking
        skip_polls = 1'b1;
        d0 = done_cnt;
        l0 = ld_cnt;
        expect_speak(16'hBEEF);
        fire(1'b0, 1'b1, 1'b0, 16'hBEEF);
        repeat (120) @(negedge clk);
        chk(ready == 1'b0, "R8", ready, 0);
        chk(ld_cnt == l0, "R8", ld_cnt, l0);
        end_gen = talk_gen;
        wait_ready();
        chk(exp_q.size() == 0, "R8", exp_q.size(), 0);
        chk(done_cnt == d0 + 1, "R8", done_cnt, d0 + 1);
        chk(speaking == 1'b1, "R5", speaking, 1);
        skip_polls = 1'b0;

        // R2 init in mid-speech clears tracking
        do_init("R2");
        chk(speaking == 1'b0, "R2", speaking, 0);
        d0 = done_cnt;
        do_poll("R2");
        chk(done_cnt == d0, "R2", done_cnt, d0);
        chk(speaking == 1'b0, "R2", speaking, 0);

        // R10 priority: init beats speak and poll
        l0 = ld_cnt;
        expect_rises("R10", 2'b11, 3);
        expect_rises("R10", 2'b00, 3);
        fire(1'b1, 1'b1, 1'b1, 16'h4321);
        wait_ready();
        chk(exp_q.size() == 0, "R10", exp_q.size(), 0);
        chk(ld_cnt == l0, "R10", ld_cnt, l0);

        // R9 no illegal code over the whole run
        chk(bad_code == 0, "R9", bad_code, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R10 watchdog actual=hung expected=complete");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule